// File: doc/BRIEF.md
# Invalidation Wait Completion Event Controller

This block finishes a wait-type invalidation descriptor. A descriptor arrives as a one-cycle strobe with two flags and two fields. The status-write flag asks for a 32-bit status value to be stored in memory. The interrupt flag asks for a completion event. The block turns the status request into a single memory write command. It turns the completion request into a sticky completion bit, a pending flag and, when the event is unmasked, an interrupt message built from two software-programmed registers.

Software sees four registers: a completion status word, an event control word holding the mask and pending flags, an event data word and an event address word. Each has its own write port and read-back output. The completion bit stays set until software clears it, and while it is set no further events are raised. An event that arrives while masked is kept as pending. Clearing the mask later replays exactly one deferred message.

Top module: `wait_event_ctrl`

## Requirements
- R1: After synchronous reset the completion bit (status bit 0) and the pending bit (control bit 30) are 0, the mask bit (control bit 31) is 1, the event data and event address registers are 0, and neither the message output nor the status write output is valid.
- R2: A descriptor with the status-write flag set produces, on the next cycle, a one-cycle status write whose byte address is the descriptor's dword address shifted left by 2 and whose data is the descriptor's status data. Without the flag, no status write is produced.
- R3: A descriptor with the interrupt flag, accepted while the completion bit is 0 and with the effective mask 0, sets the completion bit, leaves pending at 0 and emits one message on the next cycle.
- R4: The same event with the effective mask 1 sets both the completion bit and the pending bit and emits no message.
- R5: A descriptor with the interrupt flag, accepted while the completion bit is 1, changes neither completion nor pending and emits no message.
- R6: A control write stores bit 31 as the new mask. All other bits of the written value, bit 30 included, are ignored.
- R7: A control write with bit 31 = 0 while pending is 1 clears pending and emits exactly one message on the next cycle. With pending 0, unmasking emits nothing.
- R8: A status write with bit 0 = 1 clears the completion bit and the pending bit. A status write with bit 0 = 0 has no effect. A status clear in the same cycle as an unmask cancels the replay.
- R9: When an event and a control write arrive in the same cycle, the event uses the newly written mask value, and at most one message is emitted.
- R10: A message is valid for exactly one cycle. It carries the event address and event data register values that were held in the cycle before the message appears, so a same-cycle register write is not yet visible in it.
- R11: A descriptor without the interrupt flag leaves the completion bit, the pending bit and the message output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_valid | input | 1 | Wait descriptor strobe |
| wd_stat_wr | input | 1 | Descriptor requests a status write |
| wd_irq | input | 1 | Descriptor requests a completion event |
| wd_stat_data | input | 32 | Status value to store |
| wd_stat_addr | input | ADDR_W-2 | Status address in dwords |
| sw_ctl_we | input | 1 | Event control register write strobe |
| sw_ctl_wdata | input | 32 | Event control write value (bit 31 mask) |
| sw_sts_we | input | 1 | Completion status register write strobe |
| sw_sts_wdata | input | 32 | Completion status write value (bit 0 clears) |
| sw_edata_we | input | 1 | Event data register write strobe |
| sw_edata_wdata | input | 32 | Event data write value |
| sw_eaddr_we | input | 1 | Event address register write strobe |
| sw_eaddr_wdata | input | 32 | Event address write value |
| ctl_rd | output | 32 | Event control read-back (bit 31 mask, bit 30 pending) |
| sts_rd | output | 32 | Completion status read-back (bit 0) |
| edata_rd | output | 32 | Event data read-back |
| eaddr_rd | output | 32 | Event address read-back |
| st_wr_valid | output | 1 | Status write command valid |
| st_wr_addr | output | ADDR_W | Status write byte address |
| st_wr_data | output | 32 | Status write data |
| msg_valid | output | 1 | Interrupt message valid pulse |
| msg_addr | output | 32 | Interrupt message address |
| msg_data | output | 32 | Interrupt message data |

## Verification
The assertions assume that reset is applied before any strobe is used and that every input strobe is held for whole cycles only. They also rely on the pending bit being reachable only through the block's own event path, so the invariants "pending implies completion" and "pending implies masked" hold. The sweep keeps within these assumptions. Each case starts from a fresh reset and reaches its starting state (mask, completion, pending) only through legal descriptor and register writes. It then applies every combination of one cycle of descriptor and register strobes, including simultaneous ones, and checks the outcome against an arithmetic model in the bench.

// File: rtl/wcev_pkg.sv
package wcev_pkg;

    localparam int REG_W    = 32;
    localparam int COMP_BIT = 0;
    localparam int PEND_BIT = 30;
    localparam int MASK_BIT = 31;

    typedef struct packed {
        logic [REG_W-1:0] addr;
        logic [REG_W-1:0] data;
    } irq_msg_t;

    typedef struct packed {
        logic fire;
        logic comp_set;
        logic comp_clr;
        logic pend_set;
        logic pend_clr;
    } evt_dec_t;

    // Decide one cycle of completion-event behaviour.
    function automatic evt_dec_t decide_event(
        input logic ev_req,
        input logic comp_q,
        input logic pend_q,
        input logic mask_next,
        input logic unmask_wr,
        input logic sts_clr
    );
        evt_dec_t d;
        logic     ev;
        logic     replay;
        ev         = ev_req & ~comp_q;
        replay     = unmask_wr & pend_q & ~sts_clr;
        d.fire     = (ev & ~mask_next) | replay;
        d.comp_set = ev;
        d.comp_clr = sts_clr;
        d.pend_set = ev & mask_next;
        d.pend_clr = sts_clr | replay;
        return d;
    endfunction

endpackage

// File: rtl/wcev_status_wr.sv
module wcev_status_wr
    import wcev_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [REG_W-1:0]  data_in,
    input  logic [ADDR_W-3:0] dw_addr,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [REG_W-1:0]  wr_data
);
    localparam int SHIFT = 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= req;
            if (req) begin
                wr_addr <= {dw_addr, {SHIFT{1'b0}}};
                wr_data <= data_in;
            end
        end
    end
endmodule

// File: rtl/wcev_event_core.sv
module wcev_event_core
    import wcev_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_req,
    input  logic             ctl_we,
    input  logic [REG_W-1:0] ctl_wdata,
    input  logic             sts_we,
    input  logic [REG_W-1:0] sts_wdata,
    output logic             fire,
    output logic             comp_q,
    output logic             pend_q,
    output logic             mask_q
);
    logic     mask_next;
    logic     sts_clr;
    logic     unmask_wr;
    evt_dec_t dec;

    always_comb begin
        mask_next = ctl_we ? ctl_wdata[MASK_BIT] : mask_q;
        sts_clr   = sts_we & sts_wdata[COMP_BIT];
        unmask_wr = ctl_we & ~ctl_wdata[MASK_BIT];
        dec       = decide_event(ev_req, comp_q, pend_q, mask_next, unmask_wr, sts_clr);
        fire      = dec.fire;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            comp_q <= 1'b0;
            pend_q <= 1'b0;
            mask_q <= 1'b1;
        end else begin
            mask_q <= mask_next;
            if (dec.comp_set)      comp_q <= 1'b1;
            else if (dec.comp_clr) comp_q <= 1'b0;
            if (dec.pend_set)      pend_q <= 1'b1;
            else if (dec.pend_clr) pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/wcev_msg_gen.sv
module wcev_msg_gen
    import wcev_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             edata_we,
    input  logic [REG_W-1:0] edata_wdata,
    input  logic             eaddr_we,
    input  logic [REG_W-1:0] eaddr_wdata,
    output logic [REG_W-1:0] edata_q,
    output logic [REG_W-1:0] eaddr_q,
    output logic             msg_valid,
    output irq_msg_t         msg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            edata_q   <= '0;
            eaddr_q   <= '0;
            msg_valid <= 1'b0;
            msg       <= '0;
        end else begin
            if (edata_we) edata_q <= edata_wdata;
            if (eaddr_we) eaddr_q <= eaddr_wdata;
            msg_valid <= fire;
            if (fire) begin
                msg.addr <= eaddr_q;
                msg.data <= edata_q;
            end
        end
    end
endmodule

// File: rtl/wait_event_ctrl.sv
module wait_event_ctrl
    import wcev_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wd_valid,
    input  logic              wd_stat_wr,
    input  logic              wd_irq,
    input  logic [31:0]       wd_stat_data,
    input  logic [ADDR_W-3:0] wd_stat_addr,
    input  logic              sw_ctl_we,
    input  logic [31:0]       sw_ctl_wdata,
    input  logic              sw_sts_we,
    input  logic [31:0]       sw_sts_wdata,
    input  logic              sw_edata_we,
    input  logic [31:0]       sw_edata_wdata,
    input  logic              sw_eaddr_we,
    input  logic [31:0]       sw_eaddr_wdata,
    output logic [31:0]       ctl_rd,
    output logic [31:0]       sts_rd,
    output logic [31:0]       edata_rd,
    output logic [31:0]       eaddr_rd,
    output logic              st_wr_valid,
    output logic [ADDR_W-1:0] st_wr_addr,
    output logic [31:0]       st_wr_data,
    output logic              msg_valid,
    output logic [31:0]       msg_addr,
    output logic [31:0]       msg_data
);
    logic     fire;
    logic     comp_q;
    logic     pend_q;
    logic     mask_q;
    irq_msg_t msg;

    wcev_status_wr #(.ADDR_W(ADDR_W)) u_stwr (
        .clk      (clk),
        .rst      (rst),
        .req      (wd_valid & wd_stat_wr),
        .data_in  (wd_stat_data),
        .dw_addr  (wd_stat_addr),
        .wr_valid (st_wr_valid),
        .wr_addr  (st_wr_addr),
        .wr_data  (st_wr_data)
    );

    wcev_event_core u_core (
        .clk       (clk),
        .rst       (rst),
        .ev_req    (wd_valid & wd_irq),
        .ctl_we    (sw_ctl_we),
        .ctl_wdata (sw_ctl_wdata),
        .sts_we    (sw_sts_we),
        .sts_wdata (sw_sts_wdata),
        .fire      (fire),
        .comp_q    (comp_q),
        .pend_q    (pend_q),
        .mask_q    (mask_q)
    );

    wcev_msg_gen u_msg (
        .clk         (clk),
        .rst         (rst),
        .fire        (fire),
        .edata_we    (sw_edata_we),
        .edata_wdata (sw_edata_wdata),
        .eaddr_we    (sw_eaddr_we),
        .eaddr_wdata (sw_eaddr_wdata),
        .edata_q     (edata_rd),
        .eaddr_q     (eaddr_rd),
        .msg_valid   (msg_valid),
        .msg         (msg)
    );

    always_comb begin
        ctl_rd           = '0;
        ctl_rd[MASK_BIT] = mask_q;
        ctl_rd[PEND_BIT] = pend_q;
        sts_rd           = '0;
        sts_rd[COMP_BIT] = comp_q;
        msg_addr         = msg.addr;
        msg_data         = msg.data;
    end
endmodule

// File: rtl/wcev_checker.sv
module wcev_checker #(
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst,
    input logic              wd_valid,
    input logic              wd_stat_wr,
    input logic              wd_irq,
    input logic [31:0]       wd_stat_data,
    input logic [ADDR_W-3:0] wd_stat_addr,
    input logic              sw_sts_we,
    input logic [31:0]       sw_sts_wdata,
    input logic [31:0]       ctl_rd,
    input logic [31:0]       sts_rd,
    input logic              st_wr_valid,
    input logic [ADDR_W-1:0] st_wr_addr,
    input logic [31:0]       st_wr_data,
    input logic              msg_valid
);
    p_pend_needs_comp_r4: assert property (@(posedge clk) disable iff (rst)
        ctl_rd[30] |-> sts_rd[0]);

    p_pend_needs_mask_r7: assert property (@(posedge clk) disable iff (rst)
        ctl_rd[30] |-> ctl_rd[31]);

    p_msg_single_r10: assert property (@(posedge clk) disable iff (rst)
        msg_valid |=> !msg_valid);

    p_done_no_msg_r5: assert property (@(posedge clk) disable iff (rst)
        (wd_valid && wd_irq && sts_rd[0] && !ctl_rd[30]) |=> !msg_valid);

    p_status_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wd_valid && wd_stat_wr) |=> (st_wr_valid
            && st_wr_addr == {$past(wd_stat_addr), 2'b00}
            && st_wr_data == $past(wd_stat_data)));

    p_sts_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (sw_sts_we && sw_sts_wdata[0] && !(wd_valid && wd_irq && !sts_rd[0]))
            |=> (!sts_rd[0] && !ctl_rd[30]));
endmodule

bind wait_event_ctrl wcev_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wd_valid     (wd_valid),
    .wd_stat_wr   (wd_stat_wr),
    .wd_irq       (wd_irq),
    .wd_stat_data (wd_stat_data),
    .wd_stat_addr (wd_stat_addr),
    .sw_sts_we    (sw_sts_we),
    .sw_sts_wdata (sw_sts_wdata),
    .ctl_rd       (ctl_rd),
    .sts_rd       (sts_rd),
    .st_wr_valid  (st_wr_valid),
    .st_wr_addr   (st_wr_addr),
    .st_wr_data   (st_wr_data),
    .msg_valid    (msg_valid)
);

// File: tb/sim_wait_event_ctrl.sv
module sim_wait_event_ctrl;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          wd_valid, wd_stat_wr, wd_irq;
    logic [31:0]   wd_stat_data;
    logic [AW-3:0] wd_stat_addr;
    logic          sw_ctl_we, sw_sts_we, sw_edata_we, sw_eaddr_we;
    logic [31:0]   sw_ctl_wdata, sw_sts_wdata, sw_edata_wdata, sw_eaddr_wdata;
    logic [31:0]   ctl_rd, sts_rd, edata_rd, eaddr_rd;
    logic          st_wr_valid;
    logic [AW-1:0] st_wr_addr;
    logic [31:0]   st_wr_data;
    logic          msg_valid;
    logic [31:0]   msg_addr, msg_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    wait_event_ctrl #(.ADDR_W(AW)) u0 (.*);

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        wd_valid = 0; wd_stat_wr = 0; wd_irq = 0;
        sw_ctl_we = 0; sw_sts_we = 0; sw_edata_we = 0; sw_eaddr_we = 0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        idle();
        rst = 1; tick(); tick(); rst = 0;
    endtask

    task automatic op_ctl(input logic m);
        sw_ctl_we = 1; sw_ctl_wdata = {m, 31'h0}; tick(); idle();
    endtask

    task automatic op_evt();
        wd_valid = 1; wd_irq = 1; tick(); idle();
    endtask

    initial begin
        wd_stat_data = 0; wd_stat_addr = 0; sw_ctl_wdata = 0; sw_sts_wdata = 0;
        sw_edata_wdata = 0; sw_eaddr_wdata = 0;
        tick();
        do_reset();
        // R1: reset state
        chk("R1", "ctl", {32'h0, ctl_rd}, {32'h0, 32'h8000_0000});
        chk("R1", "sts", {32'h0, sts_rd}, 64'h0);
        chk("R1", "edata/eaddr", {edata_rd, eaddr_rd}, 64'h0);
        chk("R1", "outputs", {62'h0, msg_valid, st_wr_valid}, 64'h0);

        for (int s = 0; s < 5; s++) begin
            for (int st = 0; st < 256; st++) begin
                logic m, c, p, m0, c0, p0;
                logic dv, ifl, swr, cwe, cm, c30, swe, sb0;
                logic sclr, mnx, ev, rep, fire;
                logic [31:0] E, A, sd;
                logic [AW-3:0] sa;
                string lbl;
                dv = st[0]; ifl = st[1]; swr = st[2]; cwe = st[3];
                cm = st[4]; c30 = st[5]; swe = st[6]; sb0 = st[7];
                E  = 32'hD000_0000 | (s * 256 + st);
                A  = 32'hFEE0_0000 | ((s * 256 + st) << 4);
                sd = 32'hA5A5_0000 ^ (st * 32'h0101_0101);
                sa = AW'(st * 37 + s * 11 + 1);

                do_reset();
                sw_edata_we = 1; sw_edata_wdata = E;
                sw_eaddr_we = 1; sw_eaddr_wdata = A; tick(); idle();
                case (s)
                    1: op_ctl(0);
                    2: begin op_ctl(0); op_evt(); op_ctl(1); end
                    3: op_evt();
                    4: begin op_evt(); op_ctl(0); end
                    default: ;
                endcase
                m0 = (s == 0 || s == 2 || s == 3);
                c0 = (s >= 2);
                p0 = (s == 3);
                chk("R6", "setup state", {61'h0, ctl_rd[31], sts_rd[0], ctl_rd[30]}, {61'h0, m0, c0, p0});

                // apply one cycle of stimulus; register writes use other values
                wd_valid = dv; wd_irq = ifl; wd_stat_wr = swr;
                wd_stat_data = sd; wd_stat_addr = sa;
                sw_ctl_we = cwe; sw_ctl_wdata = {cm, c30, 30'h0};
                sw_sts_we = swe; sw_sts_wdata = {31'h0, sb0};
                sw_edata_we = 1; sw_edata_wdata = ~E;
                sw_eaddr_we = 1; sw_eaddr_wdata = ~A;
                tick(); idle();

                sclr = swe & sb0;
                mnx  = cwe ? cm : m0;
                ev   = dv & ifl & ~c0;
                rep  = cwe & ~cm & p0 & ~sclr;
                fire = (ev & ~mnx) | rep;
                m = mnx;
                c = ev ? 1'b1 : (sclr ? 1'b0 : c0);
                p = (ev & mnx) ? 1'b1 : ((sclr | rep) ? 1'b0 : p0);

                if (ev && cwe)            lbl = "R9";
                else if (rep || (cwe && !cm)) lbl = "R7";
                else if (ev && mnx)       lbl = "R4";
                else if (ev)              lbl = "R3";
                else if (dv && ifl)       lbl = "R5";
                else if (dv)              lbl = "R11";
                else                      lbl = "R8";

                chk(lbl, "msg_valid", {63'h0, msg_valid}, {63'h0, fire});
                if (fire)
                    chk("R10", "msg addr/data", {msg_addr, msg_data}, {A, E});
                chk("R6", "mask", {63'h0, ctl_rd[31]}, {63'h0, m});
                chk(sclr ? "R8" : lbl, "completion", {63'h0, sts_rd[0]}, {63'h0, c});
                chk(sclr ? "R8" : lbl, "pending", {63'h0, ctl_rd[30]}, {63'h0, p});
                chk("R2", "status write valid", {63'h0, st_wr_valid}, {63'h0, dv & swr});
                if (dv && swr)
                    chk("R2", "status write addr/data",
                        {16'h0, st_wr_addr, st_wr_data}, {16'h0, sa, 2'b00, sd});
                tick();
                chk("R10", "pulse ends", {62'h0, msg_valid, st_wr_valid}, 64'h0);
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule